// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital sequencer inside a single-wire LIN-style bus transceiver. It decides, from the enable input, the transmit data, a sampled bus level, an overtemperature flag and a power-good signal, whether the node drives the bus, what the receive output shows, and whether the external voltage regulator is switched on through the inhibit output. The slope shaping, comparator thresholds and protection circuits live outside it. They reach it only as digital inputs.

After power-up the block sits in a start-up state with the regulator on. A high enable moves it to normal mode, where a low transmit input pulls the bus dominant and the receive output mirrors the synchronized bus. Dropping the enable selects sleep, which switches the regulator off. In sleep, a dominant bus that lasts long enough wakes the node into stand-by. Stand-by turns the regulator back on and holds the receive output low as a wake flag until the enable returns the node to normal mode. Two guards sit on the driver: overtemperature, and a stuck-low transmit input that lasts too long.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_ni is low the block is in start-up, with inh_o=1, drv_dom_o=0 and rxd_o=1. It stays in start-up while en_i is low.
- R2: From start-up, en_i=1 at a clock edge enters normal mode at that edge. No bus wake-up is needed.
- R3: In normal mode, drv_dom_o=1 exactly when txd_i=0 (0 means dominant), with no overtemperature and no timeout. rxd_o equals bus_i (1 = recessive) as sampled two clock edges earlier. inh_o=1.
- R4: In normal mode, en_i=0 at a clock edge enters sleep. Sleep gives inh_o=0, drv_dom_o=0 and rxd_o=1.
- R5: In sleep, the bus passes through a two-flop synchronizer. The block moves to stand-by at the edge where the WAKE_CYC-th consecutive dominant synchronized sample is seen. Any recessive sample restarts the count, so shorter pulses have no effect.
- R6: In stand-by, inh_o=1, rxd_o=0 and drv_dom_o=0, whatever the bus and txd_i do.
- R7: From sleep or stand-by, en_i=1 at a clock edge enters normal mode. This clears the wake flag, and rxd_o shows bus data again.
- R8: While ot_i=1, drv_dom_o=0 in every mode. The mode sequence and rxd_o are unaffected.
- R9: In normal mode, drv_dom_o drops to 0 once txd_i has been low at TXTO_CYC consecutive clock edges. It stays 0 until txd_i has been sampled high at an edge.
- R10: pwr_good_i=0 at a clock edge returns the block to start-up from any mode. It also clears the synchronizer (to recessive) and both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply good. Low forces a synchronous return to start-up |
| en_i | input | 1 | Mode select: 1 = normal, 0 = sleep |
| txd_i | input | 1 | Transmit data, 0 = dominant |
| bus_i | input | 1 | Digitized bus level, 1 = recessive |
| ot_i | input | 1 | Overtemperature flag |
| rxd_o | output | 1 | Receive data, or the wake flag (0) in stand-by |
| drv_dom_o | output | 1 | Bus driver pulls the bus dominant |
| inh_o | output | 1 | Regulator enable |

## Verification
A wrong mode register shows up at the ports in the first cycle after the faulty edge. inh_o separates sleep from the other modes, rxd_o pinned low marks stand-by, and drv_dom_o following txd_i marks normal mode. A wake counter that is off by one moves the stand-by entry by one cycle, and the bench compares outputs every cycle against its own model, so it sees the shift. An error in the synchronizer depth shows as rxd_o out of phase with bus_i in normal mode. A timeout count that is off by one shows as drv_dom_o releasing one cycle early or late.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    M_START   = 2'd0,
    M_NORMAL  = 2'd1,
    M_SLEEP   = 2'd2,
    M_STANDBY = 2'd3
  } mode_e;
endpackage

// File: rtl/lin_sync.sv
module lin_sync #(
  parameter int STAGES = 2,
  parameter logic INIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic nxt;
    if (g == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = ff_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ff_q[g] <= INIT;
      else if (clr_i)  ff_q[g] <= INIT;
      else             ff_q[g] <= nxt;
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lin_wake_qual.sv
module lin_wake_qual #(
  parameter int WAKE_CYC = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic dom_i,
  output logic wake_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

  logic [CW-1:0] cnt_q;

  // cnt_q counts earlier consecutive dominant samples
  assign wake_o = arm_i && dom_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || !arm_i || !dom_i) cnt_q <= '0;
    else if (cnt_q != LAST)             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lin_tx_guard.sv
module lin_tx_guard #(
  parameter int TXTO_CYC = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic txd_i,
  output logic expired_o
);
  localparam int CW = $clog2(TXTO_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TXTO_CYC);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i || !arm_i || txd_i) cnt_q <= '0;
    else if (!expired_o)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int WAKE_CYC    = 12500,
  parameter int TXTO_CYC    = 1000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic en_i,
  input  logic txd_i,
  input  logic bus_i,
  input  logic ot_i,
  output logic rxd_o,
  output logic drv_dom_o,
  output logic inh_o
);
  mode_e mode_q, mode_d;
  logic  bus_s, wake, tx_expired, clr;

  assign clr = !pwr_good_i;

  lin_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .d_i   (bus_i),
    .q_o   (bus_s)
  );

  lin_wake_qual #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .arm_i (mode_q == M_SLEEP),
    .dom_i (!bus_s),
    .wake_o(wake)
  );

  lin_tx_guard #(.TXTO_CYC(TXTO_CYC)) i_tx_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .arm_i    (mode_q == M_NORMAL),
    .txd_i    (txd_i),
    .expired_o(tx_expired)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      M_START:   if (en_i) mode_d = M_NORMAL;
      M_NORMAL:  if (!en_i) mode_d = M_SLEEP;
      M_SLEEP:   if (en_i) mode_d = M_NORMAL;
                 else if (wake) mode_d = M_STANDBY;
      M_STANDBY: if (en_i) mode_d = M_NORMAL;
      default:   mode_d = M_START;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mode_q <= M_START;
    else if (clr) mode_q <= M_START;
    else          mode_q <= mode_d;
  end

  always_comb begin
    inh_o     = (mode_q != M_SLEEP);
    drv_dom_o = (mode_q == M_NORMAL) && !txd_i && !ot_i && !tx_expired;
    unique case (mode_q)
      M_NORMAL:  rxd_o = bus_s;
      M_STANDBY: rxd_o = 1'b0;  // latched wake flag
      default:   rxd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk
  import lin_mode_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input logic  pwr_good_i,
  input logic  en_i,
  input logic  txd_i,
  input logic  ot_i,
  input logic  rxd_o,
  input logic  drv_dom_o,
  input logic  inh_o,
  input mode_e mode_i
);
  p_pg_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> mode_i == M_START);

  p_en_normal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && en_i) |=> mode_i == M_NORMAL);

  p_en_low_sleep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !en_i && mode_i == M_NORMAL) |=> (mode_i == M_SLEEP && !inh_o));

  p_wake_from_sleep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_STANDBY && $past(mode_i) != M_STANDBY) |-> $past(mode_i) == M_SLEEP);

  p_standby_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == M_STANDBY |-> (!rxd_o && inh_o && !drv_dom_o));

  p_ot_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> !drv_dom_o);

  p_drv_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_dom_o |-> (mode_i == M_NORMAL && !txd_i));
endmodule

bind lin_mode_ctrl lin_mode_chk i_lin_mode_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_good_i(pwr_good_i),
  .en_i      (en_i),
  .txd_i     (txd_i),
  .ot_i      (ot_i),
  .rxd_o     (rxd_o),
  .drv_dom_o (drv_dom_o),
  .inh_o     (inh_o),
  .mode_i    (mode_q)
);

// File: tb/test_lin_mode_ctrl.sv
module test_lin_mode_ctrl;
  localparam int W  = 20;
  localparam int TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b1, en = 1'b0, txd = 1'b1, bus = 1'b1, ot = 1'b0;
  logic rxd, drv, inh;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lin_mode_ctrl #(.WAKE_CYC(W), .TXTO_CYC(TO), .SYNC_STAGES(2)) i_lin_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .en_i(en), .txd_i(txd),
    .bus_i(bus), .ot_i(ot), .rxd_o(rxd), .drv_dom_o(drv), .inh_o(inh)
  );

  // reference model: 0 start, 1 normal, 2 sleep, 3 standby
  int m_mode = 0, m_dc = 0, m_tc = 0;
  bit m_s1 = 1, m_s2 = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !pg) begin
      m_mode = 0; m_dc = 0; m_tc = 0; m_s1 = 1; m_s2 = 1;
    end else begin
      int nm;
      nm = m_mode;
      if (m_mode == 1 && !txd) m_tc = (m_tc < TO) ? m_tc + 1 : TO; else m_tc = 0;
      case (m_mode)
        0: if (en) nm = 1;
        1: if (!en) nm = 2;
        2: begin
             if (!m_s2) m_dc++; else m_dc = 0;
             if (en) nm = 1; else if (m_dc >= W) nm = 3;
           end
        3: if (en) nm = 1;
        default: nm = 0;
      endcase
      if (nm != 2) m_dc = 0;
      m_mode = nm;
      m_s2 = m_s1; m_s1 = bus;
    end
  end

  function automatic bit e_inh(); return m_mode != 2; endfunction
  function automatic bit e_rxd(); return (m_mode == 1) ? m_s2 : (m_mode == 3) ? 1'b0 : 1'b1; endfunction
  function automatic bit e_drv(); return (m_mode == 1) && !txd && !ot && (m_tc < TO); endfunction

  task automatic chk(input bit act, input bit exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(inh, e_inh(), "R4 model inh");
    chk(rxd, e_rxd(), "R3 model rxd");
    chk(drv, e_drv(), "R3 model drv");
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic look(); @(negedge clk); #1; endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    chk(inh, 1'b1, "R1 reset inh"); chk(drv, 1'b0, "R1 reset drv"); chk(rxd, 1'b1, "R1 reset rxd");
    cyc(2); rst_n = 1'b1;
    txd = 1'b0; cyc(5); look();
    chk(drv, 1'b0, "R1 start no drive"); chk(inh, 1'b1, "R1 start inh");
    txd = 1'b1; en = 1'b1; cyc(1); txd = 1'b0; look();
    chk(drv, 1'b1, "R2 normal after en"); chk(inh, 1'b1, "R2 inh on");
    // R3 mixed traffic
    for (int i = 0; i < 300; i++) begin
      txd = $urandom_range(0, 3) != 0; bus = $urandom_range(0, 1); cyc(1);
    end
    bus = 1'b0; cyc(1); bus = 1'b1; look(); chk(rxd, 1'b1, "R3 rxd lag one");
    cyc(1); look(); chk(rxd, 1'b0, "R3 rxd lag two");
    cyc(1); look(); chk(rxd, 1'b1, "R3 rxd back");
    // R9 stuck transmit
    txd = 1'b0; cyc(TO - 1); look(); chk(drv, 1'b1, "R9 before timeout");
    cyc(1); look(); chk(drv, 1'b0, "R9 at timeout");
    cyc(10); look(); chk(drv, 1'b0, "R9 held off");
    txd = 1'b1; cyc(1); txd = 1'b0; look(); chk(drv, 1'b1, "R9 rearmed");
    cyc(1);
    // R8 overtemperature
    ot = 1'b1; txd = 1'b0; bus = 1'b0; cyc(3); look();
    chk(drv, 1'b0, "R8 ot drive off"); chk(rxd, 1'b0, "R8 rxd unchanged");
    ot = 1'b0; txd = 1'b1; bus = 1'b1; cyc(3);
    // R4 sleep
    en = 1'b0; cyc(1); look();
    chk(inh, 1'b0, "R4 inh off"); chk(rxd, 1'b1, "R4 rxd high");
    txd = 1'b0; cyc(2); look(); chk(drv, 1'b0, "R4 tx disabled"); txd = 1'b1;
    // R5 short pulses ignored
    for (int k = 0; k < 4; k++) begin
      ot = (k == 2); bus = 1'b0; cyc(W - 1); bus = 1'b1; cyc(4);
    end
    ot = 1'b0; look(); chk(inh, 1'b0, "R5 short pulse ignored");
    // R5 qualified wake
    bus = 1'b0; cyc(W + 1); look(); chk(inh, 1'b0, "R5 not yet");
    cyc(1); look(); chk(inh, 1'b1, "R5 wake at count");
    // R6 standby
    bus = 1'b1; txd = 1'b0; cyc(5); look();
    chk(rxd, 1'b0, "R6 wake flag"); chk(drv, 1'b0, "R6 no drive"); chk(inh, 1'b1, "R6 inh");
    // R7 back to normal
    en = 1'b1; txd = 1'b1; cyc(1); look(); chk(rxd, 1'b1, "R7 flag cleared");
    bus = 1'b0; cyc(2); look(); chk(rxd, 1'b0, "R7 follows bus");
    bus = 1'b1; en = 1'b0; cyc(5);
    en = 1'b1; cyc(1); txd = 1'b0; look(); chk(drv, 1'b1, "R7 sleep to normal");
    txd = 1'b1;
    // R10 power fail
    pg = 1'b0; cyc(1); pg = 1'b1; en = 1'b0; txd = 1'b0; cyc(1); look();
    chk(drv, 1'b0, "R10 start after pg"); chk(inh, 1'b1, "R10 inh on");
    en = 1'b1; txd = 1'b1; cyc(3); en = 1'b0; cyc(3); pg = 1'b0; cyc(1); look();
    chk(inh, 1'b1, "R10 sleep to start");
    pg = 1'b1; cyc(3); look(); chk(inh, 1'b1, "R1 stays start en low");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule